// File: doc/BRIEF.md
# LSB-First Serial Register Access Port

This block is a slave serial port that gives an external host read and write access to a bank of 64 eight-bit registers. The host pulls the active-low chip select low and clocks one 16-bit frame on the serial clock. Each bit goes out least significant first. Bit 0 selects the direction. Bits 1 to 6 carry the register address, with its lowest bit first. Bit 7 is ignored. Bits 8 to 15 carry the data byte, with its lowest bit first. In a write frame the port collects the whole byte and then issues a single write strobe toward the register bank. In a read frame the port fetches the addressed register once the header ends and shifts that byte out on the serial data output.

All serial inputs pass through a synchronizer into the fast system clock domain, where the port detects the edges of the serial clock. A static edge-select input chooses the serial clock edge on which the port samples incoming bits. Outgoing read bits change on the opposite edge. A controller with six states runs the frame:

- ST_IDLE leads to ST_HDR when chip select goes active.
- ST_HDR leads to ST_WDATA (direction 0) or to ST_RDATA (direction 1) after the eighth bit is sampled.
- ST_WDATA leads to ST_COMMIT after the sixteenth bit.
- ST_RDATA leads to ST_WAIT after the sixteenth bit.
- ST_COMMIT always leads to ST_WAIT.
- ST_WAIT holds until chip select is released and then returns to ST_IDLE.
- Releasing chip select in ST_HDR, ST_WDATA, ST_RDATA or ST_WAIT returns the controller to ST_IDLE.

Top module: `lsb_serial_regport`

## Requirements
- R1: A frame is 16 sampled bits in transfer order. Bit 0 is the direction (1 = read, 0 = write). Bits 1..6 are address bits 0..5, in that order. Bits 8..15 are data bits 0..7, in that order.
- R2: A complete write frame asserts `reg_we` for exactly one system clock cycle. During that cycle `reg_addr` holds the frame address and `reg_wdata` holds the frame byte.
- R3: If chip select is released before the sixteenth bit of a write frame is sampled, no write takes place. `reg_we` is asserted only after all 16 bits have been counted.
- R4: In a read frame the port captures `reg_rdata` when bit 7 is sampled. It then presents data bits 0..7 on `sdo` for frame bits 8..15, one bit per serial clock, least significant first.
- R5: Outside the read data phase, `sdo_oe` is 0 and `sdo` is 0. In particular `sdo_oe` is 0 during bits 0..7 and after bit 15.
- R6: With `edge_sel` = 0 the port samples `sdi` on the rising edge of `sclk` and changes `sdo` on the falling edge. With `edge_sel` = 1 the two edges are swapped.
- R7: The value of bit 7 has no effect on the access.
- R8: After reset, `reg_we`, `sdo_oe` and `sdo` are 0.
- R9: Serial clock edges that arrive after bit 15 while chip select is still active are ignored. They produce no second write and no further read output.
- R10: A read frame never asserts `reg_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data in |
| edge_sel | input | 1 | 0: sample on rising sclk; 1: sample on falling sclk |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | DATA_W | Register write data |
| reg_rdata | input | DATA_W | Register read data for reg_addr |

## Verification
The assertions check several properties on every cycle: the write strobe lasts a single cycle, it fires only with the bit count at a full frame, `sdo` stays low whenever it is not enabled, the output enable appears only in read frames, and the controller returns to idle when chip select is released mid-frame. The bench scenarios cover the properties that depend on values. These are the LSB-first ordering of address and data, a read returning what an earlier write stored under both sampling edges, bit 7 having no effect, truncated frames leaving the register untouched, and surplus clock edges after the frame doing nothing.

// File: rtl/regport_pkg.sv
package regport_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HDR    = 3'd1,
        ST_WDATA  = 3'd2,
        ST_RDATA  = 3'd3,
        ST_COMMIT = 3'd4,
        ST_WAIT   = 3'd5
    } rp_state_e;

    localparam logic DIR_READ = 1'b1;

endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/regport_edge.sv
module regport_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic edge_sel,
    output logic smp,
    output logic lnch
);

    logic prev_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sclk_s;
    end

    always_comb begin
        rise = sclk_s & ~prev_q;
        fall = ~sclk_s & prev_q;
        smp  = edge_sel ? fall : rise;
        lnch = edge_sel ? rise : fall;
    end

endmodule

// File: rtl/regport_fsm.sv
module regport_fsm
    import regport_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 8,
    parameter int FRAME      = 16,
    parameter int DATA_START = 8,
    parameter int CNT_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              smp,
    input  logic              sdi_s,
    output rp_state_e         state,
    output logic [CNT_W-1:0]  cnt,
    output logic              rw,
    output logic              we,
    output logic              load_rd,
    output logic              rd_phase,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);

    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(DATA_START - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(FRAME - 1);

    rp_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              rw_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              shifting;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_act) state_d = ST_HDR;
            end
            ST_HDR: begin
                if (!cs_act)
                    state_d = ST_IDLE;
                else if (smp && cnt_q == HDR_LAST)
                    state_d = (rw_q == DIR_READ) ? ST_RDATA : ST_WDATA;
            end
            ST_WDATA: begin
                if (!cs_act)
                    state_d = ST_IDLE;
                else if (smp && cnt_q == BIT_LAST)
                    state_d = ST_COMMIT;
            end
            ST_RDATA: begin
                if (!cs_act)
                    state_d = ST_IDLE;
                else if (smp && cnt_q == BIT_LAST)
                    state_d = ST_WAIT;
            end
            ST_COMMIT: state_d = ST_WAIT;
            ST_WAIT: begin
                if (!cs_act) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        we       = (state_q == ST_COMMIT);
        rd_phase = (state_q == ST_RDATA);
        shifting = smp && (state_q == ST_HDR || state_q == ST_WDATA
                           || state_q == ST_RDATA);
        load_rd  = smp && (state_q == ST_HDR) && (cnt_q == HDR_LAST)
                   && (rw_q == DIR_READ);
    end

    // bit counter and captured fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rw_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE) begin
            cnt_q <= '0;
        end else if (shifting) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == '0) rw_q <= sdi_s;
            for (int i = 0; i < ADDR_W; i++) begin
                if (cnt_q == CNT_W'(i + 1)) addr_q[i] <= sdi_s;
            end
            if (state_q == ST_WDATA) begin
                for (int j = 0; j < DATA_W; j++) begin
                    if (cnt_q == CNT_W'(DATA_START + j)) wdata_q[j] <= sdi_s;
                end
            end
        end
    end

    assign state = state_q;
    assign cnt   = cnt_q;
    assign rw    = rw_q;
    assign addr  = addr_q;
    assign wdata = wdata_q;

endmodule

// File: rtl/regport_txshift.sv
module regport_txshift #(
    parameter int DATA_W     = 8,
    parameter int DATA_START = 8,
    parameter int CNT_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_rd,
    input  logic              lnch,
    input  logic              rd_phase,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DATA_W-1:0] rdata,
    output logic              sdo,
    output logic              sdo_oe
);

    logic [DATA_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh_q <= '0;
        else if (load_rd)
            sh_q <= rdata;
        else if (lnch && rd_phase && cnt > CNT_W'(DATA_START))
            sh_q <= sh_q >> 1;
    end

    assign sdo    = rd_phase & sh_q[0];
    assign sdo_oe = rd_phase;

endmodule

// File: rtl/lsb_serial_regport.sv
module lsb_serial_regport
    import regport_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              edge_sel,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int DATA_START = ADDR_W + 2;
    localparam int FRAME      = DATA_START + DATA_W;
    localparam int CNT_W      = $clog2(FRAME + 1);

    logic [2:0]       sync_q;
    logic             cs_act;
    logic             smp;
    logic             lnch;
    rp_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rw_q;
    logic             load_rd;
    logic             rd_phase;

    regport_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({cs_n, sclk, sdi}),
        .q_sync  (sync_q)
    );

    assign cs_act = ~sync_q[2];

    regport_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sync_q[1]),
        .edge_sel (edge_sel),
        .smp      (smp),
        .lnch     (lnch)
    );

    regport_fsm #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .FRAME      (FRAME),
        .DATA_START (DATA_START),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .smp      (smp),
        .sdi_s    (sync_q[0]),
        .state    (state_q),
        .cnt      (cnt_q),
        .rw       (rw_q),
        .we       (reg_we),
        .load_rd  (load_rd),
        .rd_phase (rd_phase),
        .addr     (reg_addr),
        .wdata    (reg_wdata)
    );

    regport_txshift #(
        .DATA_W     (DATA_W),
        .DATA_START (DATA_START),
        .CNT_W      (CNT_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_rd  (load_rd),
        .lnch     (lnch),
        .rd_phase (rd_phase),
        .cnt      (cnt_q),
        .rdata    (reg_rdata),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

endmodule

// File: rtl/lsb_serial_regport_chk.sv
module lsb_serial_regport_chk
    import regport_pkg::*;
#(
    parameter int FRAME = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_act,
    input rp_state_e        state_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             rw_q,
    input logic             reg_we,
    input logic             sdo,
    input logic             sdo_oe
);

    p_we_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    p_we_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> cnt_q == CNT_W'(FRAME));

    p_sdo_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

    p_oe_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (rw_q == DIR_READ && !reg_we));

    p_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && state_q != ST_IDLE && state_q != ST_COMMIT)
        |=> state_q == ST_IDLE);

    p_wait_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_WAIT |=> (!reg_we && !sdo_oe));

    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(FRAME));

endmodule

bind lsb_serial_regport lsb_serial_regport_chk #(
    .FRAME (FRAME),
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_act  (cs_act),
    .state_q (state_q),
    .cnt_q   (cnt_q),
    .rw_q    (rw_q),
    .reg_we  (reg_we),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe)
);

// File: tb/lsb_serial_regport_bench.sv
`timescale 1ns/1ps
module lsb_serial_regport_bench;

    localparam int H = 8;           // system clocks per sclk half period
    localparam int NV = 10;

    // {edge_sel, rw, bit7, addr[5:0], data[7:0]}
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 6'h05, 8'hA5},
        {1'b0, 1'b1, 1'b0, 6'h05, 8'h00},
        {1'b1, 1'b0, 1'b1, 6'h3F, 8'h3C},
        {1'b1, 1'b1, 1'b1, 6'h3F, 8'hFF},
        {1'b0, 1'b0, 1'b1, 6'h00, 8'h81},
        {1'b1, 1'b1, 1'b0, 6'h00, 8'h00},
        {1'b1, 1'b0, 1'b0, 6'h2A, 8'h5A},
        {1'b0, 1'b1, 1'b1, 6'h2A, 8'h00},
        {1'b0, 1'b1, 1'b0, 6'h11, 8'h00},
        {1'b1, 1'b1, 1'b0, 6'h20, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       edge_sel = 1'b0;
    logic       sdo;
    logic       sdo_oe;
    logic       reg_we;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    logic [7:0] bank [64];
    logic [7:0] exp_bank [64];
    int         we_cnt = 0;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 0;

    always #2.5 clk = ~clk;

    lsb_serial_regport u_lsb_serial_regport (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .edge_sel  (edge_sel),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    assign reg_rdata = bank[reg_addr];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) bank[i] <= 8'(i * 7 + 3);
        end else if (reg_we) begin
            bank[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive one frame; bits past 15 repeat alternating values
    task automatic run_frame(input logic es, input logic [15:0] fr, input int nbits,
                             output logic [7:0] rd, output logic early_oe);
        rd = '0;
        early_oe = 1'b0;
        edge_sel = es;
        sclk = es;
        wait_clk(H);
        cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? fr[i] : i[0];
            wait_clk(H);
            if (i >= 8 && i < 16) rd[i-8] = sdo;
            if (i < 8 && sdo_oe) early_oe = 1'b1;
            sclk = ~es;
            wait_clk(H);
            sclk = es;
        end
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(4 * H);
    endtask

    function automatic logic [15:0] mk(input logic rw, input logic b7,
                                       input logic [5:0] a, input logic [7:0] d);
        return {d, b7, a, rw};
    endfunction

    initial begin
        logic [7:0] rd;
        logic       eo;
        int         w0;
        for (int i = 0; i < 64; i++) exp_bank[i] = 8'(i * 7 + 3);
        wait_clk(5);
        // R8: reset state
        check(reg_we == 0 && sdo_oe == 0 && sdo == 0, "R8 reset outputs",
              {reg_we, sdo_oe, sdo}, 0);
        rst_n = 1'b1;
        wait_clk(5);
        check(reg_we == 0 && sdo_oe == 0, "R8 after reset release", {reg_we, sdo_oe}, 0);

        for (int v = 0; v < NV; v++) begin
            logic       es, rw, b7;
            logic [5:0] a;
            logic [7:0] d;
            {es, rw, b7, a, d} = VEC[v];
            w0 = we_cnt;
            run_frame(es, mk(rw, b7, a, d), 16, rd, eo);
            if (!rw) begin
                exp_bank[a] = d;
                check(we_cnt == w0 + 1, "R2 single write strobe", we_cnt - w0, 1);
                check(bank[a] == d, "R1/R7 write lands at LSB-first address", bank[a], d);
            end else begin
                check(rd == exp_bank[a], "R4/R6 read data LSB first", rd, exp_bank[a]);
                check(we_cnt == w0, "R10 read causes no write", we_cnt - w0, 0);
                check(!eo && !sdo_oe, "R5 sdo_oe off outside data phase", {eo, sdo_oe}, 0);
            end
        end

        // R3: chip select released after 10 bits
        w0 = we_cnt;
        run_frame(1'b0, mk(1'b0, 1'b0, 6'h09, 8'hEE), 10, rd, eo);
        check(we_cnt == w0, "R3 abort after 10 bits", we_cnt - w0, 0);
        run_frame(1'b0, mk(1'b1, 1'b0, 6'h09, 8'h00), 16, rd, eo);
        check(rd == exp_bank[9], "R3 register untouched after abort", rd, exp_bank[9]);

        // R3: released after 15 bits
        w0 = we_cnt;
        run_frame(1'b1, mk(1'b0, 1'b0, 6'h09, 8'h11), 15, rd, eo);
        check(we_cnt == w0, "R3 abort after 15 bits", we_cnt - w0, 0);
        run_frame(1'b1, mk(1'b1, 1'b0, 6'h09, 8'h00), 16, rd, eo);
        check(rd == exp_bank[9], "R3 register untouched after late abort", rd, exp_bank[9]);

        // R9: extra edges after a write frame
        w0 = we_cnt;
        run_frame(1'b0, mk(1'b0, 1'b0, 6'h33, 8'hC3), 20, rd, eo);
        exp_bank[6'h33] = 8'hC3;
        check(we_cnt == w0 + 1, "R9 one write despite extra edges", we_cnt - w0, 1);
        check(bank[6'h33] == 8'hC3, "R9 written value kept", bank[6'h33], 8'hC3);

        // R9: extra edges after a read frame
        run_frame(1'b1, mk(1'b1, 1'b0, 6'h33, 8'h00), 20, rd, eo);
        check(rd == 8'hC3, "R9 read with extra edges", rd, 8'hC3);
        check(!sdo_oe && !sdo, "R5 outputs quiet after frame", {sdo_oe, sdo}, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule